// File: doc/BRIEF.md
# Bidirectional Bus Transceiver Register

This block passes an 18-bit word in each of two directions, side A to side B and side B to side A. Each direction has its own storage element. A per-direction hold control selects how that element behaves. With the hold control high, the element is transparent and the input bus flows straight through to the output. With it low, the element keeps its value. It captures a new word only on a rising edge of that direction's own strobe input.

Each side drives its bus through a data output and a separate drive-enable output, so no internal tri-state nets exist. The A-to-B drive control is active high and the B-to-A drive control is active low. The drive controls gate only the enable outputs; capture goes on while driving is off.

The strobes are level inputs sampled by the system clock `clk`. A rising strobe edge is a sample of 1 that follows a sample of 0, and the captured word appears on the output after that `clk` edge.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's pass control (`ab_pass` / `ba_pass`) is 1, that direction's data output equals its input bus in the same cycle, combinationally.
- R2: While the pass control is 0 and no rising strobe edge is sampled, the data output keeps its stored value. A steady strobe or a falling strobe has no effect.
- R3: While the pass control is 0, a strobe sampled as 1 on a `clk` edge after being sampled 0 on the previous edge captures the input bus. The word is visible on the data output from that edge on.
- R4: When the pass control falls while the strobe is steady high, no capture happens. The output keeps the word that was flowing through on the last `clk` edge with the pass control high.
- R5: `b_drv` equals `ab_drv` (active high). A 1 on `b_drv` means side B is driven and a 0 means high impedance.
- R6: `a_drv` equals the inverse of `ba_drv_n` (active low). A 1 on `a_drv` means side A is driven.
- R7: Storage updates while the drive enable of that direction is off. A word captured while driving was disabled is on the data output when driving is enabled again.
- R8: Active-low `rst_n` clears both stored words to zero. A strobe that is already high when reset is released is not treated as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and updates storage |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 18 | Word received from side A |
| b_in | input | 18 | Word received from side B |
| ab_pass | input | 1 | A-to-B pass control: 1 transparent, 0 hold/clocked |
| ab_stb | input | 1 | A-to-B capture strobe, rising edge captures |
| ab_drv | input | 1 | A-to-B drive control, active high |
| ba_pass | input | 1 | B-to-A pass control |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_drv_n | input | 1 | B-to-A drive control, active low |
| b_out | output | 18 | Word presented to side B |
| b_drv | output | 1 | Side B driver enable |
| a_out | output | 18 | Word presented to side A |
| a_drv | output | 1 | Side A driver enable |

## Verification
Random traffic mixes pass-control levels with strobes that rise, fall or stay put, and uses new data words every cycle. This separates flow-through from capture and from hold. It also exposes a design that captures on falling or static strobes. Directed cases cover three situations. One releases the pass control under a high strobe, which catches a spurious capture at that moment. One captures with driving disabled and then enables driving. One releases reset with a strobe already high. Both directions run at once with different words, so a swapped lane or a polarity slip on a drive control shows up.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    ST_FLOW = 2'd0,
    ST_HOLD = 2'd1,
    ST_GRAB = 2'd2
  } st_mode_e;

  // A rising strobe: sampled high now after being sampled low before.
  function automatic logic rise_seen(input logic now_lvl, input logic last_lvl);
    return now_lvl & ~last_lvl;
  endfunction

  // Pass control wins; otherwise a rising strobe captures; otherwise hold.
  function automatic st_mode_e pick_mode(input logic pass, input logic rise);
    if (pass)      return ST_FLOW;
    else if (rise) return ST_GRAB;
    else           return ST_HOLD;
  endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  import ubt_pkg::*;

  logic last_q;

  // Reset value 1: a strobe already high at reset release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= lvl;
  end

  assign rise = rise_seen(lvl, last_q);
endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         rise,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         cap_ev
);
  import ubt_pkg::*;

  st_mode_e     mode;
  logic [W-1:0] word_q;

  assign mode   = pick_mode(pass, rise);
  assign cap_ev = (mode == ST_GRAB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      case (mode)
        ST_FLOW, ST_GRAB: word_q <= d;
        default:          word_q <= word_q;
      endcase
    end
  end

  assign q = (mode == ST_FLOW) ? d : word_q;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int W      = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         stb,
  input  logic         drv_raw,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         drv,
  output logic         cap_ev
);
  logic rise;

  ubt_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (stb),
    .rise (rise)
  );

  ubt_store_cell #(.W(W)) u_cell (
    .clk   (clk),
    .rst_n (rst_n),
    .pass  (pass),
    .rise  (rise),
    .d     (d),
    .q     (q),
    .cap_ev(cap_ev)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign drv = ~drv_raw;
    end else begin : g_oe_high
      assign drv = drv_raw;
    end
  endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_pass,
  input  logic         ab_stb,
  input  logic         ab_drv,
  input  logic         ba_pass,
  input  logic         ba_stb,
  input  logic         ba_drv_n,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  // Capture events brought out for the checker.
  logic ab_cap;
  logic ba_cap;

  ubt_lane #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk    (clk),
    .rst_n  (rst_n),
    .pass   (ab_pass),
    .stb    (ab_stb),
    .drv_raw(ab_drv),
    .d      (a_in),
    .q      (b_out),
    .drv    (b_drv),
    .cap_ev (ab_cap)
  );

  ubt_lane #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk    (clk),
    .rst_n  (rst_n),
    .pass   (ba_pass),
    .stb    (ba_stb),
    .drv_raw(ba_drv_n),
    .d      (b_in),
    .q      (a_out),
    .drv    (a_drv),
    .cap_ev (ba_cap)
  );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_pass,
  input logic         ab_stb,
  input logic         ba_pass,
  input logic         ba_stb,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_out,
  input logic         ab_cap,
  input logic         ba_cap
);
  assert_ab_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |-> (b_out == a_in));

  assert_ba_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |-> (a_out == b_in));

  assert_ab_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !ab_cap) |=> (ab_pass || b_out == $past(b_out)));

  assert_ba_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && !ba_cap) |=> (ba_pass || a_out == $past(a_out)));

  assert_ab_grab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cap |=> (ab_pass || b_out == $past(a_in)));

  assert_ba_grab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ba_cap |=> (ba_pass || a_out == $past(b_in)));

  assert_ab_no_spur_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ab_pass) && ab_stb && $past(ab_stb)) |-> (!ab_cap && b_out == $past(b_out)));

  assert_ba_no_spur_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ba_pass) && ba_stb && $past(ba_stb)) |-> (!ba_cap && a_out == $past(a_out)));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_in   (a_in),
  .b_in   (b_in),
  .ab_pass(ab_pass),
  .ab_stb (ab_stb),
  .ba_pass(ba_pass),
  .ba_stb (ba_stb),
  .b_out  (b_out),
  .a_out  (a_out),
  .ab_cap (ab_cap),
  .ba_cap (ba_cap)
);

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ab_pass, ab_stb, ab_drv, ba_pass, ba_stb, ba_drv_n;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ubt_xcvr #(.W(W)) u_ubt_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_drv(ab_drv),
    .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_drv_n(ba_drv_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  // Bench reference: stored word and last sampled strobe per direction.
  logic [W-1:0] m_ab, m_ba;
  logic         s_ab, s_ba;

  function automatic logic [W-1:0] next_word(input logic pass, input logic stb,
                                             input logic last, input logic [W-1:0] din,
                                             input logic [W-1:0] cur);
    if (pass || (stb && !last)) return din;
    return cur;
  endfunction

  function automatic logic [W-1:0] seen(input logic pass, input logic [W-1:0] din,
                                        input logic [W-1:0] cur);
    return pass ? din : cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; s_ab <= 1'b1; s_ba <= 1'b1;
    end else begin
      m_ab <= next_word(ab_pass, ab_stb, s_ab, a_in, m_ab);
      m_ba <= next_word(ba_pass, ba_stb, s_ba, b_in, m_ba);
      s_ab <= ab_stb;
      s_ba <= ba_stb;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic pass, input logic stb, input logic last);
    if (pass) return "R1";
    if (stb && !last) return "R3";
    return "R2";
  endfunction

  // Compare everything against the reference (called after drive, before posedge).
  logic lst_ab, lst_ba;
  task automatic chk_all();
    chk("R5", {17'd0, b_drv}, {17'd0, ab_drv});
    chk("R6", {17'd0, a_drv}, {17'd0, ~ba_drv_n});
    chk(mode_tag(ab_pass, lst_ab, 1'b0), b_out, seen(ab_pass, a_in, m_ab));
    chk(mode_tag(ba_pass, lst_ba, 1'b0), a_out, seen(ba_pass, b_in, m_ba));
  endtask

  task automatic step();
    @(negedge clk);
    lst_ab = ab_stb; lst_ba = ba_stb;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; a_in = 18'h15A5A; b_in = 18'h2A5A5;
    ab_pass = 1'b0; ab_stb = 1'b1; ab_drv = 1'b0;
    ba_pass = 1'b0; ba_stb = 1'b1; ba_drv_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset clears both words
    chk("R8", b_out, '0);
    chk("R8", a_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: strobes high at reset release are not edges
    chk("R8", b_out, '0);
    chk("R8", a_out, '0);

    // R4: pass control falls while strobe stays high
    ab_pass = 1'b1; ba_pass = 1'b1; a_in = 18'h11111; b_in = 18'h22222;
    @(negedge clk);
    ab_pass = 1'b0; ba_pass = 1'b0; a_in = 18'h3FFFF; b_in = 18'h00F0F;
    repeat (3) @(negedge clk);
    chk("R4", b_out, 18'h11111);
    chk("R4", a_out, 18'h22222);

    // R7: capture while driving disabled, then enable
    ab_stb = 1'b0; ba_stb = 1'b0;
    @(negedge clk);
    a_in = 18'h0BEEF; b_in = 18'h1CAFE; ab_stb = 1'b1; ba_stb = 1'b1;
    @(negedge clk);
    a_in = 18'h00000; b_in = 18'h00000;
    chk("R7", {17'd0, b_drv}, 18'd0);
    ab_drv = 1'b1; ba_drv_n = 1'b0; #1;
    chk("R7", b_out, 18'h0BEEF);
    chk("R7", a_out, 18'h1CAFE);
    chk("R7", {17'd0, a_drv}, 18'd1);

    // Random traffic with pass control mostly low
    for (int i = 0; i < 3000; i++) begin
      step();
      a_in = W'($urandom); b_in = W'($urandom);
      ab_pass = ($urandom % 4) == 0; ba_pass = ($urandom % 4) == 0;
      ab_stb = $urandom % 2; ba_stb = $urandom % 2;
      ab_drv = $urandom % 2; ba_drv_n = $urandom % 2;
      #1;
      chk_all();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule